// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block judges whether a phase-locked loop has settled. Once per phase detector cycle it receives a single-cycle pulse marking the reference-divider edge and another marking the feedback-divider edge. Both pulses are already synchronised to a fast timing clock. The block measures how many timing-clock ticks separate the two pulses. It adds a programmable delay allowance and checks the sum against a tolerance window chosen by a 3-bit code. Each comparison is reported as a pass or an error.

A filter turns the stream of comparisons into a lock flag with hysteresis. A run of consecutive passes of programmable length declares lock and also clears the stored error count. Errors are counted up to a programmable maximum, and the flag drops once that maximum is exceeded. A combined lock output ANDs the flag with an external good indication from a charge-pump voltage monitor.

Top module: `dld_lock_detector`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `dld_lock` and `cmp_valid` are low. Reset clears the pass run and the error count, so a full new run of passes is needed before lock.
- R2: The separation is counted in timing-clock ticks from whichever pulse arrives first. A second pulse k cycles later gives `cmp_sep` = k. Pulses in the same cycle give 0. `cmp_valid` is high for one cycle, in the cycle after the edge where the second pulse is sampled.
- R3: A comparison passes (`cmp_pass`=1) when `cmp_sep` + `dly_code`×DLY_STEP ≤ window(`tol_code`). Otherwise it is an error. The windows for codes 0..5 are 1, 2, 3, 6, 10 and 18 ticks by default.
- R4: The reserved tolerance codes 6 and 7 use the widest window, 18 ticks by default.
- R5: If the other pulse does not arrive within SAT_TICKS ticks (default 64), a comparison is issued with `cmp_sep` = SAT_TICKS and is always an error.
- R6: `dld_lock` rises when the number of consecutive passes reaches `pass_thr`. A value of 0 acts as 1.
- R7: An error restarts the pass run, so earlier passes do not count towards lock.
- R8: Completing a pass run also clears the accumulated error count.
- R9: `dld_lock` falls on the error that makes the error count exceed `err_max`. With `err_max`=0, a single error removes lock.
- R10: `lock_out` is high only when `dld_lock` and `cpm_good` are both high.
- R11: While the block waits for the second pulse, a further pulse on the side that started the measurement is ignored and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | Reference-divider edge, one cycle |
| fb_pulse | input | 1 | Feedback-divider edge, one cycle |
| tol_code | input | 3 | Tolerance window code |
| dly_code | input | 2 | Delay allowance code |
| pass_thr | input | 8 | Passes needed to declare lock |
| err_max | input | 5 | Errors tolerated before unlock |
| cpm_good | input | 1 | Charge-pump voltage good |
| cmp_valid | output | 1 | Comparison result strobe |
| cmp_pass | output | 1 | Comparison passed |
| cmp_sep | output | SEP_W (7) | Measured separation in ticks |
| dld_lock | output | 1 | Digital lock flag |
| lock_out | output | 1 | Lock flag AND charge-pump good |

## Verification
The hardest state to reach is a locked flag with a partly filled error count that is then wiped by a later pass run. Seen from the ports, this only shows up as lock surviving a number of errors it would not otherwise survive. The stimulus locks the loop and injects exactly `err_max` errors. It then completes a fresh pass run and injects `err_max` errors again, checking that lock holds. One further error must then drop it. Missing edges, reserved codes and repeated same-side pulses are driven as explicit pulse timelines whose separations the scoreboard predicts.

// File: rtl/dld_pkg.sv
package dld_pkg;
    // Measurement state of the edge separation meter
    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_WAIT = 1'b1
    } meter_state_e;

    // Number of tolerance codes (3-bit field)
    localparam int unsigned TOL_CODES = 8;
endpackage

// File: rtl/dld_edge_meter.sv
// Edge separation meter.
// Measures the tick distance between a reference pulse and a feedback pulse,
// starting from whichever arrives first. Assumes both inputs are single-cycle
// pulses in the clk domain. Produces one registered result per pair, or a
// saturated result when the partner pulse is missing for SAT_TICKS ticks.
module dld_edge_meter
    import dld_pkg::*;
#(
    parameter int unsigned SAT_TICKS = 64,
    parameter int unsigned SEP_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    output logic             meas_valid,
    output logic [SEP_W-1:0] meas_sep
);
    localparam logic [SEP_W-1:0] SAT_V = SEP_W'(SAT_TICKS);

    meter_state_e     state_q;
    logic             from_ref_q;
    logic [SEP_W-1:0] cnt_q;
    logic             partner;

    // Select the pulse that closes the current measurement
    always_comb begin
        partner = from_ref_q ? fb_pulse : ref_pulse;
    end

    // Track the open measurement and emit its result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= MS_IDLE;
            from_ref_q <= 1'b0;
            cnt_q      <= '0;
            meas_valid <= 1'b0;
            meas_sep   <= '0;
        end else begin
            meas_valid <= 1'b0;
            case (state_q)
                MS_IDLE: begin
                    if (ref_pulse && fb_pulse) begin
                        meas_valid <= 1'b1;
                        meas_sep   <= '0;
                    end else if (ref_pulse || fb_pulse) begin
                        state_q    <= MS_WAIT;
                        from_ref_q <= ref_pulse;
                        cnt_q      <= SEP_W'(1);
                    end
                end
                MS_WAIT: begin
                    if (partner) begin
                        meas_valid <= 1'b1;
                        meas_sep   <= cnt_q;
                        state_q    <= MS_IDLE;
                    end else if (cnt_q == SAT_V) begin
                        meas_valid <= 1'b1;
                        meas_sep   <= SAT_V;
                        state_q    <= MS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + SEP_W'(1);
                    end
                end
                default: state_q <= MS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dld_window_judge.sv
// Tolerance window judge.
// Maps the tolerance code to a window in ticks (reserved codes use the
// widest window), adds the delay allowance to the measured separation and
// flags a pass when the sum fits inside the window. Purely combinational.
module dld_window_judge
    import dld_pkg::*;
#(
    parameter int unsigned SEP_W     = 7,
    parameter int unsigned DLY_STEP  = 1,
    parameter int unsigned TOL0      = 1,
    parameter int unsigned TOL1      = 2,
    parameter int unsigned TOL2      = 3,
    parameter int unsigned TOL3      = 6,
    parameter int unsigned TOL4      = 10,
    parameter int unsigned TOL5      = 18
) (
    input  logic [SEP_W-1:0] meas_sep,
    input  logic [2:0]       tol_code,
    input  logic [1:0]       dly_code,
    output logic             fits
);
    localparam int unsigned SUM_W = SEP_W + 3;

    logic [SUM_W-1:0] win_lut [TOL_CODES];
    logic [SUM_W-1:0] allow;
    logic [SUM_W-1:0] total;

    // Build the window table; codes beyond 5 share the widest window
    for (genvar c = 0; c < TOL_CODES; c++) begin : g_win
        if (c == 0) begin : g_c0
            assign win_lut[c] = SUM_W'(TOL0);
        end else if (c == 1) begin : g_c1
            assign win_lut[c] = SUM_W'(TOL1);
        end else if (c == 2) begin : g_c2
            assign win_lut[c] = SUM_W'(TOL2);
        end else if (c == 3) begin : g_c3
            assign win_lut[c] = SUM_W'(TOL3);
        end else if (c == 4) begin : g_c4
            assign win_lut[c] = SUM_W'(TOL4);
        end else begin : g_cw
            assign win_lut[c] = SUM_W'(TOL5);
        end
    end

    // Add the allowance and compare against the selected window
    always_comb begin
        allow = SUM_W'(dly_code) * SUM_W'(DLY_STEP);
        total = SUM_W'(meas_sep) + allow;
        fits  = (total <= win_lut[tol_code]);
    end
endmodule

// File: rtl/dld_lock_filter.sv
// Lock hysteresis filter.
// Counts consecutive passing comparisons and accumulated errors. A completed
// pass run sets the lock flag and clears the error count; an error that
// pushes the count above the maximum clears the flag. Assumes at most one
// comparison result per cycle.
module dld_lock_filter #(
    parameter int unsigned PASS_W = 8,
    parameter int unsigned ERR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic              cmp_pass,
    input  logic [PASS_W-1:0] pass_thr,
    input  logic [ERR_W-1:0]  err_max,
    output logic              lock
);
    logic [PASS_W-1:0] run_q;
    logic [ERR_W:0]    err_q;
    logic [PASS_W:0]   run_next;
    logic [ERR_W:0]    err_next;
    logic              run_done;
    logic              err_over;

    // Next counter values and threshold decisions
    always_comb begin
        run_next = {1'b0, run_q} + (PASS_W+1)'(1);
        run_done = (run_next >= {1'b0, pass_thr});
        err_next = (&err_q) ? err_q : err_q + (ERR_W+1)'(1);
        err_over = (err_next > {1'b0, err_max});
    end

    // Update counters and lock flag on each comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            err_q <= '0;
            lock  <= 1'b0;
        end else if (cmp_valid) begin
            if (cmp_pass) begin
                if (run_done) begin
                    lock  <= 1'b1;
                    run_q <= '0;
                    err_q <= '0;
                end else begin
                    run_q <= run_next[PASS_W-1:0];
                end
            end else begin
                run_q <= '0;
                err_q <= err_next;
                if (err_over) begin
                    lock <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/dld_lock_detector.sv
// Digital PLL lock detector, top level.
// Chains the edge separation meter, the tolerance window judge and the lock
// hysteresis filter, and gates the lock flag with the external charge-pump
// good input. Assumes SAT_TICKS exceeds the widest window plus the largest
// allowance, so a missing edge always judges as an error.
module dld_lock_detector
    import dld_pkg::*;
#(
    parameter int unsigned SAT_TICKS = 64,
    parameter int unsigned DLY_STEP  = 1,
    parameter int unsigned TOL_TICKS_0 = 1,
    parameter int unsigned TOL_TICKS_1 = 2,
    parameter int unsigned TOL_TICKS_2 = 3,
    parameter int unsigned TOL_TICKS_3 = 6,
    parameter int unsigned TOL_TICKS_4 = 10,
    parameter int unsigned TOL_TICKS_5 = 18,
    parameter int unsigned PASS_W    = 8,
    parameter int unsigned ERR_W     = 5,
    localparam int unsigned SEP_W    = $clog2(SAT_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              fb_pulse,
    input  logic [2:0]        tol_code,
    input  logic [1:0]        dly_code,
    input  logic [PASS_W-1:0] pass_thr,
    input  logic [ERR_W-1:0]  err_max,
    input  logic              cpm_good,
    output logic              cmp_valid,
    output logic              cmp_pass,
    output logic [SEP_W-1:0]  cmp_sep,
    output logic              dld_lock,
    output logic              lock_out
);
    logic fits;

    dld_edge_meter #(
        .SAT_TICKS(SAT_TICKS),
        .SEP_W    (SEP_W)
    ) meter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .meas_valid(cmp_valid),
        .meas_sep  (cmp_sep)
    );

    dld_window_judge #(
        .SEP_W   (SEP_W),
        .DLY_STEP(DLY_STEP),
        .TOL0    (TOL_TICKS_0),
        .TOL1    (TOL_TICKS_1),
        .TOL2    (TOL_TICKS_2),
        .TOL3    (TOL_TICKS_3),
        .TOL4    (TOL_TICKS_4),
        .TOL5    (TOL_TICKS_5)
    ) judge_i (
        .meas_sep(cmp_sep),
        .tol_code(tol_code),
        .dly_code(dly_code),
        .fits    (fits)
    );

    assign cmp_pass = fits;

    dld_lock_filter #(
        .PASS_W(PASS_W),
        .ERR_W (ERR_W)
    ) filter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_valid(cmp_valid),
        .cmp_pass (fits),
        .pass_thr (pass_thr),
        .err_max  (err_max),
        .lock     (dld_lock)
    );

    // Qualify the digital flag with the charge-pump monitor
    always_comb begin
        lock_out = dld_lock & cpm_good;
    end
endmodule

// File: rtl/dld_lock_checker.sv
// Property checker for the lock detector, bound to every instance of the top.
module dld_lock_checker #(
    parameter int unsigned SAT_TICKS = 64,
    parameter int unsigned SEP_W     = 7,
    parameter int unsigned TOL0      = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       tol_code,
    input logic [1:0]       dly_code,
    input logic             cpm_good,
    input logic             cmp_valid,
    input logic             cmp_pass,
    input logic [SEP_W-1:0] cmp_sep,
    input logic             dld_lock,
    input logic             lock_out
);
    a_r10_needs_cpm: assert property (@(posedge clk) disable iff (!rst_n)
        lock_out |-> (cpm_good && dld_lock));

    a_r6_rise_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dld_lock) |-> $past(cmp_valid && cmp_pass));

    a_r9_fall_after_error: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dld_lock) |-> $past(cmp_valid && !cmp_pass));

    a_r5_sep_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (cmp_sep <= SEP_W'(SAT_TICKS)));

    a_r5_saturated_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_sep == SEP_W'(SAT_TICKS)) |-> !cmp_pass);

    a_r3_narrow_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && tol_code == 3'd0 && dly_code == 2'd0 && cmp_sep > SEP_W'(TOL0))
        |-> !cmp_pass);
endmodule

bind dld_lock_detector dld_lock_checker #(
    .SAT_TICKS(SAT_TICKS),
    .SEP_W    (SEP_W),
    .TOL0     (TOL_TICKS_0)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tol_code (tol_code),
    .dly_code (dly_code),
    .cpm_good (cpm_good),
    .cmp_valid(cmp_valid),
    .cmp_pass (cmp_pass),
    .cmp_sep  (cmp_sep),
    .dld_lock (dld_lock),
    .lock_out (lock_out)
);

// File: tb/dld_lock_detector_tb_top.sv
module dld_lock_detector_tb_top;
    localparam int SAT = 64;
    localparam int SW  = $clog2(SAT + 1);

    typedef struct {
        int    sep;
        bit    pass;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_pulse = 1'b0;
    logic          fb_pulse = 1'b0;
    logic [2:0]    tol_code = 3'd5;
    logic [1:0]    dly_code = 2'd0;
    logic [7:0]    pass_thr = 8'd3;
    logic [4:0]    err_max = 5'd1;
    logic          cpm_good = 1'b1;
    logic          cmp_valid;
    logic          cmp_pass;
    logic [SW-1:0] cmp_sep;
    logic          dld_lock;
    logic          lock_out;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    dld_lock_detector dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .tol_code(tol_code), .dly_code(dly_code), .pass_thr(pass_thr),
        .err_max(err_max), .cpm_good(cpm_good), .cmp_valid(cmp_valid),
        .cmp_pass(cmp_pass), .cmp_sep(cmp_sep), .dld_lock(dld_lock),
        .lock_out(lock_out)
    );

    function automatic int win_of(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 6;
            4: return 10;
            default: return 18;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one pulse pair, first side leading by k ticks
    task automatic pair(bit ref_first, int k, string req);
        exp_t e;
        e.sep  = k;
        e.pass = (k + int'(dly_code)) <= win_of(int'(tol_code));
        e.req  = req;
        sb_q.push_back(e);
        @(negedge clk);
        if (k == 0) begin
            ref_pulse = 1'b1; fb_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0; fb_pulse = 1'b0;
        end else begin
            if (ref_first) ref_pulse = 1'b1; else fb_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0; fb_pulse = 1'b0;
            repeat (k - 1) @(negedge clk);
            if (ref_first) fb_pulse = 1'b1; else ref_pulse = 1'b1;
            @(negedge clk);
            ref_pulse = 1'b0; fb_pulse = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    // Driver: only one edge, partner never arrives
    task automatic lone(bit ref_side, string req);
        exp_t e;
        e.sep = SAT; e.pass = 1'b0; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        if (ref_side) ref_pulse = 1'b1; else fb_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0; fb_pulse = 1'b0;
        repeat (SAT + 3) @(negedge clk);
    endtask

    // Monitor: compare each comparison result with the queue head
    always @(negedge clk) begin
        if (rst_n && cmp_valid) begin
            if (sb_q.size() == 0) begin
                check("R2 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " sep"}, int'(cmp_sep), e.sep);
                check({e.req, " pass"}, int'(cmp_pass), int'(e.pass));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 lock in reset", int'(dld_lock), 0);
        check("R1 valid in reset", int'(cmp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lock after reset", int'(dld_lock), 0);
        check("R1 lock_out after reset", int'(lock_out), 0);

        // R2/R3 wide window, both orders and simultaneous; R6 locks on third
        pair(1'b1, 5, "R2 ref first");
        pair(1'b0, 18, "R3 fb first at window edge");
        check("R6 not yet locked", int'(dld_lock), 0);
        pair(1'b1, 0, "R2 simultaneous");
        check("R6 locked after run", int'(dld_lock), 1);
        check("R10 lock_out with good", int'(lock_out), 1);
        cpm_good = 1'b0;
        @(negedge clk);
        check("R10 lock_out without good", int'(lock_out), 0);
        cpm_good = 1'b1;

        // R3/R9 narrow window, err_max=1
        tol_code = 3'd0;
        pair(1'b1, 1, "R3 tol0 k1");
        pair(1'b1, 2, "R3 tol0 k2");
        check("R9 one error tolerated", int'(dld_lock), 1);
        pair(1'b0, 3, "R3 tol0 k3");
        check("R9 unlock over max", int'(dld_lock), 0);

        // R7 an error restarts the pass run
        pair(1'b1, 1, "R7 pass a");
        pair(1'b1, 1, "R7 pass b");
        pair(1'b1, 4, "R7 error");
        pair(1'b0, 1, "R7 pass c");
        pair(1'b0, 0, "R7 pass d");
        check("R7 run restarted", int'(dld_lock), 0);
        pair(1'b1, 1, "R7 pass e");
        check("R7 locked after full run", int'(dld_lock), 1);

        // R8 completing a run clears the error count
        err_max = 5'd2; pass_thr = 8'd2;
        pair(1'b1, 5, "R8 err1");
        pair(1'b1, 5, "R8 err2");
        check("R8 two errors tolerated", int'(dld_lock), 1);
        pair(1'b1, 0, "R8 pass1");
        pair(1'b1, 1, "R8 pass2");
        pair(1'b0, 5, "R8 err3");
        pair(1'b0, 5, "R8 err4");
        check("R8 errors were cleared", int'(dld_lock), 1);
        pair(1'b0, 5, "R8 err5");
        check("R9 unlock third error", int'(dld_lock), 0);

        // R3 delay allowance
        tol_code = 3'd2; dly_code = 2'd2;
        pair(1'b1, 1, "R3 tol2 dly2 k1");
        pair(1'b1, 2, "R3 tol2 dly2 k2");
        tol_code = 3'd3; dly_code = 2'd3;
        pair(1'b0, 3, "R3 tol3 dly3 k3");
        pair(1'b0, 4, "R3 tol3 dly3 k4");
        tol_code = 3'd4; dly_code = 2'd0;
        pair(1'b1, 10, "R3 tol4 k10");
        pair(1'b1, 11, "R3 tol4 k11");
        tol_code = 3'd1;
        pair(1'b0, 2, "R3 tol1 k2");
        pair(1'b0, 3, "R3 tol1 k3");

        // R4 reserved codes
        tol_code = 3'd6;
        pair(1'b1, 18, "R4 code6 k18");
        pair(1'b1, 19, "R4 code6 k19");
        tol_code = 3'd7;
        pair(1'b0, 18, "R4 code7 k18");

        // R5 missing partner edge
        lone(1'b1, "R5 ref alone");
        lone(1'b0, "R5 fb alone");

        // R11 repeated same-side pulse ignored
        tol_code = 3'd4;
        begin
            exp_t e;
            e.sep = 4; e.pass = 1'b1; e.req = "R11 repeat ref";
            sb_q.push_back(e);
            @(negedge clk); ref_pulse = 1'b1;
            @(negedge clk); ref_pulse = 1'b0;
            @(negedge clk); ref_pulse = 1'b1;
            @(negedge clk); ref_pulse = 1'b0;
            @(negedge clk); fb_pulse = 1'b1;
            @(negedge clk); fb_pulse = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R9 err_max=0: single error unlocks
        err_max = 5'd0;
        pair(1'b1, 1, "R9 relock pass");
        check("R9 relocked", int'(dld_lock), 1);
        pair(1'b1, 12, "R9 single error");
        check("R9 single error unlocks", int'(dld_lock), 0);

        // R1 reset clears the pass run
        pair(1'b1, 0, "R1 pre pass");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 lock cleared by reset", int'(dld_lock), 0);
        rst_n = 1'b1;
        pair(1'b1, 0, "R1 post pass1");
        check("R1 run cleared by reset", int'(dld_lock), 0);
        pair(1'b0, 2, "R1 post pass2");
        check("R1 relock after run", int'(dld_lock), 1);

        // R6 threshold 0 behaves as 1
        pass_thr = 8'd0;
        pair(1'b1, 15, "R6 error before thr0");
        check("R6 unlocked before thr0", int'(dld_lock), 0);
        pair(1'b1, 3, "R6 thr0 pass");
        check("R6 thr0 locks on one pass", int'(dld_lock), 1);

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule